// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and a slower memory. Stores leaving the cache, whether write-through traffic or dirty lines pushed out by a replacement, are queued in a small buffer. They drain to memory in the background over a single memory port. Read misses share that port. A read miss does not wait for the queue to empty. Its address is compared against every queued entry. If nothing matches, the read takes the port ahead of all pending stores.

When a queued store does match a read, the build-time parameter `FWD_EN` selects the behaviour. With forwarding on, the read is answered straight from the buffer and never reaches memory. With forwarding off, the read is held until the matching store has been written to memory, and is then read back from memory. A store to an address already in the queue overwrites that entry's data in place. The queue is four entries deep by default. A full flag blocks new stores. A dirty victim that is handed over in the same cycle as its read miss is therefore written after the read.

Top module: `wrbuf_bypass`

## Requirements
- R1: After a synchronous active-low reset, `mem_valid` is low, `wr_full` is low, `rd_ready` is high and `rd_resp_valid` is low.
- R2: Accepted stores reach memory as write requests (`mem_we`=1) in arrival order, each carrying the data it was given.
- R3: With DEPTH (4) distinct entries queued, `wr_full` is high, and a store presented while `wr_full` is high is dropped and never reaches memory.
- R4: A store whose address matches a queued entry replaces that entry's data, takes no new slot and keeps the entry's place in the drain order.
- R5: A read whose address matches no queued entry is presented on the memory port (`mem_we`=0) in the cycle after it is accepted, and it is sent before any store that is still queued.
- R6: A store and a read miss to a different address, both accepted in the same cycle, reach memory read first, then store.
- R7: With `FWD_EN`=1, a read that matches a queued entry returns that entry's current data, with `rd_resp_valid` rising on the edge after the accepting edge, and it issues no memory read.
- R8: With `FWD_EN`=0, a read that matches a queued entry issues no memory read until that entry has been written to memory. It then reads memory and returns the stored data.
- R9: A read served from memory returns `mem_rdata` as captured in the cycle when `mem_rvalid` is high.
- R10: Every accepted read gives exactly one single-cycle `rd_resp_valid` pulse. `rd_ready` is low from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Store request, accepted when `wr_full` is low |
| wr_addr | input | AW | Store word address |
| wr_data | input | DW | Store data |
| wr_full | output | 1 | All entries occupied; stores are refused |
| rd_valid | input | 1 | Read-miss request, accepted when `rd_ready` is high |
| rd_addr | input | AW | Read word address |
| rd_ready | output | 1 | No read is in progress |
| rd_resp_valid | output | 1 | One-cycle pulse carrying the read result |
| rd_resp_data | output | DW | Read result |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = drained store, 0 = read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Store data for memory |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
Suppose an entry's valid bit or a queue pointer goes wrong. The result then shows on the memory port at the next drain: a store is lost, repeated, written with stale data or written out of order. The memory model's log records this within a few cycles of `mem_ready` rising. A broken address compare shows in one of two ways. Forwarding may give wrong data one edge after acceptance, or a read may reach memory ahead of the store it depends on. The hold-mode instance exposes the second case through stale read data. A broken read state machine shows as a missing or doubled response pulse, or as `rd_ready` staying low.

// File: rtl/wrbuf_pkg.sv
// Shared types for the write buffer with read bypass.
package wrbuf_pkg;
    // Read-path states: idle, address compare against the queue, waiting on memory data.
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_LOOKUP = 2'd1,
        RD_WAIT   = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wrbuf_store.sv
// Circular store queue. It appends new stores at the tail, rewrites a matching
// entry in place on a merge, and removes the head when it drains.
// Assumes: push without merge is never given while full, and pop is never given while empty.
module wrbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic [DEPTH-1:0]          merge_vec,
    input  logic                      pop,
    output logic [DEPTH-1:0]          ent_vld,
    output logic [DEPTH-1:0][AW-1:0]  ent_addr,
    output logic [DEPTH-1:0][DW-1:0]  ent_data,
    output logic [DEPTH-1:0]          head_vec,
    output logic [AW-1:0]             head_addr,
    output logic [DW-1:0]             head_data,
    output logic                      full,
    output logic                      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]         vld_q;
    logic [DEPTH-1:0][AW-1:0] addr_q;
    logic [DEPTH-1:0][DW-1:0] data_q;
    logic [PW-1:0]            head_q, tail_q;
    logic [CW-1:0]            count_q;
    logic                     merge;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign merge = |merge_vec;

    // Queue update: merge or append on push, retire the head on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push && merge) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (merge_vec[i]) data_q[i] <= push_data;
                end
            end else if (push) begin
                addr_q[tail_q] <= push_addr;
                data_q[tail_q] <= push_data;
                vld_q[tail_q]  <= 1'b1;
                tail_q         <= ptr_next(tail_q);
            end
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= ptr_next(head_q);
            end
            count_q <= count_q + CW'(push && !merge) - CW'(pop);
        end
    end

    // One-hot marker of the head slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_head
        assign head_vec[g] = (head_q == PW'(g));
    end

    assign ent_vld   = vld_q;
    assign ent_addr  = addr_q;
    assign ent_data  = data_q;
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];
    assign full      = (count_q == CW'(DEPTH));
    assign empty     = (count_q == '0);

    // R3: occupancy never exceeds the queue depth.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R3: a new slot is only taken while one is free.
    a_r3_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !merge) |-> (count_q < CW'(DEPTH)));
    // R2: a drain only happens with something queued.
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count_q != '0));
endmodule

// File: rtl/wrbuf_match.sv
// Compares a read address against every valid queue entry in parallel and
// returns the data of the matching entry.
// Assumes: merging keeps at most one valid entry per address.
module wrbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH-1:0]          ent_vld,
    input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]  ent_data,
    input  logic [AW-1:0]             key,
    output logic                      hit,
    output logic [DW-1:0]             hit_data
);
    logic [DEPTH-1:0] match;

    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_addr[g] == key);
    end

    // AND-OR select of the matching entry's data.
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_data = hit_data | (ent_data[i] & {DW{match[i]}});
        end
    end

    assign hit = |match;

    // R4: merging leaves no address queued twice.
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/wrbuf_rd_ctrl.sv
// Read-miss sequencer. It latches one read, checks the queue, and then either
// forwards from the buffer, holds, or reads memory and returns the data.
// Assumes: at most one read in flight; memory answers each read exactly once.
module wrbuf_rd_ctrl
    import wrbuf_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter bit FWD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic [AW-1:0] lk_addr,
    input  logic          lk_hit,
    input  logic [DW-1:0] lk_data,
    output logic          rd_issue,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data
);
    rd_state_e     state_q;
    logic [AW-1:0] addr_q;
    logic          resp_valid_q;
    logic [DW-1:0] resp_data_q;

    // The memory port is wanted only by a looked-up read with no queue match.
    assign rd_issue = (state_q == RD_LOOKUP) && !lk_hit;
    assign rd_ready = (state_q == RD_IDLE);
    assign lk_addr  = addr_q;

    // Read state machine and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RD_IDLE;
            addr_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (rd_valid) begin
                        addr_q  <= rd_addr;
                        state_q <= RD_LOOKUP;
                    end
                end
                RD_LOOKUP: begin
                    if (lk_hit) begin
                        if (FWD_EN) begin
                            resp_data_q  <= lk_data;
                            resp_valid_q <= 1'b1;
                            state_q      <= RD_IDLE;
                        end
                    end else if (mem_ready) begin
                        state_q <= RD_WAIT;
                    end
                end
                RD_WAIT: begin
                    if (mem_rvalid) begin
                        resp_data_q  <= mem_rdata;
                        resp_valid_q <= 1'b1;
                        state_q      <= RD_IDLE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

    // R10: the response is a single-cycle pulse.
    a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_q |=> !resp_valid_q);
    // R10: a response leaves the sequencer ready for the next read.
    a_r10_idle_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_q |-> (state_q == RD_IDLE));
endmodule

// File: rtl/wrbuf_bypass.sv
// Write buffer with read bypass. It queues stores from the cache, drains them
// in FIFO order on a shared memory port, and gives a pending read miss priority
// on that port. Reads that match a queued store are forwarded or held (FWD_EN).
// Assumes: memory accepts at most one request per cycle and returns read data
// in order; the cache presents a victim no later than its read miss.
module wrbuf_bypass #(
    parameter int DEPTH  = 4,
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter bit FWD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    logic [DEPTH-1:0]         ent_vld;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0]         head_vec;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic                     q_full, q_empty;
    logic [DEPTH-1:0]         wr_match, merge_vec;
    logic                     push, pop;
    logic [AW-1:0]            lk_addr;
    logic                     lk_hit;
    logic [DW-1:0]            lk_data;
    logic                     rd_issue;

    // Store-side compare used for merging.
    for (genvar g = 0; g < DEPTH; g++) begin : g_wcmp
        assign wr_match[g] = ent_vld[g] && (ent_addr[g] == wr_addr);
    end

    // Port arbitration: a waiting read wins, otherwise the head drains.
    assign push      = wr_valid && !q_full;
    assign pop       = !rd_issue && !q_empty && mem_ready;
    // A head leaving this cycle carries its old data, so it cannot take a merge.
    assign merge_vec = wr_match & ~(head_vec & {DEPTH{pop}});

    assign mem_valid = rd_issue || !q_empty;
    assign mem_we    = !rd_issue;
    assign mem_addr  = rd_issue ? lk_addr : head_addr;
    assign mem_wdata = head_data;
    assign wr_full   = q_full;

    wrbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .merge_vec (merge_vec),
        .pop       (pop),
        .ent_vld   (ent_vld),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .head_vec  (head_vec),
        .head_addr (head_addr),
        .head_data (head_data),
        .full      (q_full),
        .empty     (q_empty)
    );

    wrbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_vld  (ent_vld),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .key      (lk_addr),
        .hit      (lk_hit),
        .hit_data (lk_data)
    );

    wrbuf_rd_ctrl #(.AW(AW), .DW(DW), .FWD_EN(FWD_EN)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .lk_addr    (lk_addr),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .rd_issue   (rd_issue),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .resp_valid (rd_resp_valid),
        .resp_data  (rd_resp_data)
    );
endmodule

// File: tb/wrbuf_bypass_tb.sv
// Small memory model: 16 words, read data one cycle after the handshake, and a log of every request.
module wrbuf_bypass_mem (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [31:0] wdata,
    input  logic        ready,
    output logic        rvalid,
    output logic [31:0] rdata
);
    logic [31:0] words [16];
    logic        pend;
    logic [3:0]  paddr;
    logic        log_we   [32];
    logic [15:0] log_addr [32];
    logic [31:0] log_data [32];
    int          log_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) words[i] <= 32'h5EED_0000 | i;
            pend  <= 1'b0;
            paddr <= '0;
            log_n <= 0;
        end else begin
            pend <= 1'b0;
            if (valid && ready) begin
                if (we) words[addr[3:0]] <= wdata;
                else begin
                    pend  <= 1'b1;
                    paddr <= addr[3:0];
                end
                if (log_n < 32) begin
                    log_we[log_n]   <= we;
                    log_addr[log_n] <= addr;
                    log_data[log_n] <= wdata;
                end
                log_n <= log_n + 1;
            end
        end
    end
    assign rvalid = pend;
    assign rdata  = words[paddr];
endmodule

module wrbuf_bypass_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        mem_ready = 1'b1;

    logic        full_a, rdy_a, resp_a, mv_a, mwe_a, rv_a;
    logic [31:0] rdat_a, mwd_a, mrd_a;
    logic [15:0] ma_a;
    logic        full_b, rdy_b, resp_b, mv_b, mwe_b, rv_b;
    logic [31:0] rdat_b, mwd_b, mrd_b;
    logic [15:0] ma_b;

    int n_chk = 0, n_fail = 0, cyc = 0, t0 = 0;
    bit got_a = 0, got_b = 0;
    logic [31:0] dat_a, dat_b;
    int cyc_a = 0, cyc_b = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wrbuf_bypass #(.FWD_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_full(full_a), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy_a),
        .rd_resp_valid(resp_a), .rd_resp_data(rdat_a), .mem_valid(mv_a), .mem_we(mwe_a),
        .mem_addr(ma_a), .mem_wdata(mwd_a), .mem_ready(mem_ready), .mem_rvalid(rv_a),
        .mem_rdata(mrd_a));
    wrbuf_bypass_mem u_mem_a (.clk(clk), .rst_n(rst_n), .valid(mv_a), .we(mwe_a), .addr(ma_a),
        .wdata(mwd_a), .ready(mem_ready), .rvalid(rv_a), .rdata(mrd_a));

    wrbuf_bypass #(.FWD_EN(1'b0)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_full(full_b), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rdy_b),
        .rd_resp_valid(resp_b), .rd_resp_data(rdat_b), .mem_valid(mv_b), .mem_we(mwe_b),
        .mem_addr(ma_b), .mem_wdata(mwd_b), .mem_ready(mem_ready), .mem_rvalid(rv_b),
        .mem_rdata(mrd_b));
    wrbuf_bypass_mem u_mem_b (.clk(clk), .rst_n(rst_n), .valid(mv_b), .we(mwe_b), .addr(ma_b),
        .wdata(mwd_b), .ready(mem_ready), .rvalid(rv_b), .rdata(mrd_b));

    // Response capture away from the active edge.
    always @(negedge clk) begin
        if (resp_a) begin
            if (got_a) begin n_chk++; n_fail++; $display("FAIL R10 extra pulse fwd act=1 exp=0"); end
            got_a = 1; dat_a = rdat_a; cyc_a = cyc;
        end
        if (resp_b) begin
            if (got_b) begin n_chk++; n_fail++; $display("FAIL R10 extra pulse hold act=1 exp=0"); end
            got_b = 1; dat_b = rdat_b; cyc_b = cyc;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd_pulse(input logic [15:0] a);
        got_a = 0; got_b = 0;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_both();
        for (int k = 0; k < 40 && !(got_a && got_b); k++) @(negedge clk);
    endtask

    task automatic settle();
        mem_ready = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic chk_log_a(input int i, input bit we, input logic [15:0] a, input logic [31:0] d,
                             input bit cmp_d, input string req);
        chk(u_mem_a.log_we[i] == we && u_mem_a.log_addr[i] == a &&
            (!cmp_d || u_mem_a.log_data[i] == d), req, {u_mem_a.log_we[i], 15'd0, u_mem_a.log_addr[i]},
            {we, 15'd0, a});
        if (cmp_d) chk(u_mem_a.log_data[i] == d, req, u_mem_a.log_data[i], d);
    endtask

    task automatic t_reset();
        chk(mv_a == 1'b0, "R1 mem_valid", 32'(mv_a), 0);
        chk(full_a == 1'b0, "R1 wr_full", 32'(full_a), 0);
        chk(rdy_a == 1'b1, "R1 rd_ready", 32'(rdy_a), 1);
        chk(resp_a == 1'b0, "R1 rd_resp_valid", 32'(resp_a), 0);
    endtask

    task automatic t_fifo();
        int base = u_mem_a.log_n;
        mem_ready = 1'b0;
        wr(16'd1, 32'hA001); wr(16'd2, 32'hA002); wr(16'd3, 32'hA003);
        settle();
        chk(u_mem_a.log_n - base == 3, "R2 drain count", 32'(u_mem_a.log_n - base), 3);
        chk_log_a(base,     1, 16'd1, 32'hA001, 1, "R2 order0");
        chk_log_a(base + 1, 1, 16'd2, 32'hA002, 1, "R2 order1");
        chk_log_a(base + 2, 1, 16'd3, 32'hA003, 1, "R2 order2");
    endtask

    task automatic t_full();
        int base = u_mem_a.log_n;
        mem_ready = 1'b0;
        for (int i = 4; i < 8; i++) wr(16'(i), 32'hB000 + i);
        chk(full_a == 1'b1, "R3 full after four", 32'(full_a), 1);
        wr(16'd8, 32'hB008);
        chk(full_a == 1'b1, "R3 still full", 32'(full_a), 1);
        settle();
        chk(u_mem_a.log_n - base == 4, "R3 dropped store absent", 32'(u_mem_a.log_n - base), 4);
        chk_log_a(base + 3, 1, 16'd7, 32'hB007, 1, "R3 last drained");
    endtask

    task automatic t_merge();
        int base = u_mem_a.log_n;
        mem_ready = 1'b0;
        wr(16'd9, 32'hC001); wr(16'd10, 32'hC002); wr(16'd9, 32'hC003);
        settle();
        chk(u_mem_a.log_n - base == 2, "R4 merged count", 32'(u_mem_a.log_n - base), 2);
        chk_log_a(base,     1, 16'd9,  32'hC003, 1, "R4 merged entry first");
        chk_log_a(base + 1, 1, 16'd10, 32'hC002, 1, "R4 second entry");
    endtask

    task automatic t_bypass();
        int base = u_mem_a.log_n;
        mem_ready = 1'b0;
        wr(16'd1, 32'hD001); wr(16'd2, 32'hD002);
        rd_pulse(16'd13);
        chk(mv_a && !mwe_a && ma_a == 16'd13, "R5 port carries read",
            {mv_a, mwe_a, 14'd0, ma_a}, {2'b10, 14'd0, 16'd13});
        chk(rdy_a == 1'b0, "R10 busy during read", 32'(rdy_a), 0);
        mem_ready = 1'b1;
        wait_both();
        chk(got_a && dat_a == 32'h5EED_000D, "R9 miss data fwd", dat_a, 32'h5EED_000D);
        chk(got_b && dat_b == 32'h5EED_000D, "R9 miss data hold", dat_b, 32'h5EED_000D);
        settle();
        chk_log_a(base,     0, 16'd13, 0, 0, "R5 read first");
        chk_log_a(base + 1, 1, 16'd1, 32'hD001, 1, "R5 store after read");
        chk(rdy_a == 1'b1, "R10 ready after response", 32'(rdy_a), 1);
    endtask

    task automatic t_victim();
        int base = u_mem_a.log_n;
        mem_ready = 1'b1;
        got_a = 0; got_b = 0;
        wr_valid = 1'b1; wr_addr = 16'd14; wr_data = 32'hE00E;
        rd_valid = 1'b1; rd_addr = 16'd15;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        wait_both();
        chk(got_a && dat_a == 32'h5EED_000F, "R6 read data", dat_a, 32'h5EED_000F);
        settle();
        chk_log_a(base,     0, 16'd15, 0, 0, "R6 read before victim");
        chk_log_a(base + 1, 1, 16'd14, 32'hE00E, 1, "R6 victim after read");
    endtask

    task automatic t_fwd_hold();
        int base_a = u_mem_a.log_n;
        int base_b = u_mem_b.log_n;
        mem_ready = 1'b0;
        wr(16'd3, 32'hF001); wr(16'd3, 32'hF002);
        rd_pulse(16'd3);
        for (int k = 0; k < 10; k++) @(negedge clk);
        chk(got_a && dat_a == 32'hF002, "R7 forwarded data", dat_a, 32'hF002);
        chk(cyc_a - t0 == 1, "R7 forward timing", 32'(cyc_a - t0), 1);
        chk(got_b == 0, "R8 held while store queued", 32'(got_b), 0);
        mem_ready = 1'b1;
        for (int k = 0; k < 40 && !got_b; k++) @(negedge clk);
        chk(got_b && dat_b == 32'hF002, "R8 data after drain", dat_b, 32'hF002);
        settle();
        chk(u_mem_a.log_n - base_a == 1 && u_mem_a.log_we[base_a] == 1'b1,
            "R7 no memory read", 32'(u_mem_a.log_n - base_a), 1);
        chk(u_mem_b.log_n - base_b == 2 && u_mem_b.log_we[base_b] == 1'b1 &&
            u_mem_b.log_we[base_b + 1] == 1'b0 && u_mem_b.log_addr[base_b + 1] == 16'd3,
            "R8 store then read", 32'(u_mem_b.log_n - base_b), 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo();
        t_full();
        t_merge();
        t_bypass();
        t_victim();
        t_fwd_hold();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule